// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Routing Controller

This block collects level-sensitive interrupt requests from on-board devices and expansion slots, masks them, and steers them to one of up to four processors. Each processor also owns a small group of soft-interrupt flags that any bus master can raise or lower. Another processor can use them as inter-processor interrupts. Every processor receives a 4-bit priority level. That level is the highest priority among its own pending soft interrupts and, for the one processor picked as the target, the unmasked pending device requests.

Software reaches the block through a simple word-wide register bus. Each processor has its own 4 KB page of registers. The system-wide page follows directly after the last processor page. Set and clear ports act only on the bits written as 1, so software never needs a read-modify-write sequence to change one source.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every system mask bit reads 1, including the mask-all bit 31. All soft-interrupt flags read 0, the target register reads 0, and every processor level is 0.
- R2: A write to processor c's set port at offset 0x8 of page c sets the soft flags written as 1 in bits 31..17. The flag for level n sits at bit 16+n. Bits written as 0 and bits 16..0 have no effect.
- R3: A write to processor c's clear port at offset 0x4 of page c clears the soft flags written as 1 and leaves the others unchanged.
- R4: On the system page, writing 1s to offset 0x8 sets those mask bits, which disables those sources. Writing 1s to offset 0xC clears them, which enables those sources. Offset 0x4 reads the mask.
- R5: Offset 0x0 of the system page reads the device request lines as sampled on the previous clock, whether masked or not. Only the source positions read: bits 0..22 and 28..30. All other bits read 0.
- R6: While mask bit 31 is set, no device request reaches any processor level. Soft interrupts are not affected by the mask.
- R7: Source priorities are fixed. Bits 0..6 and the expansion levels at bits 7..13 map in pairs k and k+7 to levels 2,3,5,7,9,11,13. Keyboard/mouse (14) and serial (15) map to 12, ethernet (16) to 6, audio (17) to 13, SCSI (18) to 4, timer (19) to 10, video (20) to 8, module (21) to 9, floppy (22) to 11, and the error sources (28, 29, 30) to 15.
- R8: Offset 0x10 of the system page is a read/write target index. Its low bits choose the only processor that receives device requests. All other processors see only their soft level.
- R9: Each processor's level is the maximum of its highest pending soft level and, for the target, the highest unmasked pending device level. The level is 0 when neither is pending.
- R10: Write-only ports, unmapped offsets and pages beyond the system page read 0. Writes to them, and to read-only registers, change nothing.
- R11: Read data is registered. It appears in the cycle after the request and is 0 in any cycle that follows no read. Levels follow register state combinationally, so a write or a request change shows on the levels right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 15 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| dev_req | input | 32 | Level-sensitive device request lines |
| cpu_level | output | 16 | Per-processor 4-bit priority level, processor c at bits 4c+3..4c |

## Verification
A bus write takes effect at the clock edge that captures it. Its effect on any level is visible at the next falling edge, and a read issued in the following cycle returns the new value at the falling edge after that. A device request change becomes visible through the sampling register one edge later, so the timing check looks at the level both 1 ns after the change, where it must still hold the old value, and one full cycle later. The reference model advances at each rising edge with the same inputs, and every comparison and directed check samples at the falling edge, so each result is read in the cycle in which it is due and never at a clock edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int WORD_W       = 32;
    localparam int LVL_W        = 4;
    localparam int PAGE_BITS    = 12;
    localparam int SOFT_N       = 15;
    localparam int SOFT_LSB     = 17;
    localparam int MASK_ALL_BIT = 31;

    // Positions that carry a real device request
    localparam logic [WORD_W-1:0] SRC_VALID = 32'h707F_FFFF;

    // Per-processor page offsets
    localparam logic [PAGE_BITS-1:0] OFF_CPU_PEND = 12'h000;
    localparam logic [PAGE_BITS-1:0] OFF_CPU_CLR  = 12'h004;
    localparam logic [PAGE_BITS-1:0] OFF_CPU_SET  = 12'h008;

    // System page offsets
    localparam logic [PAGE_BITS-1:0] OFF_SYS_PEND = 12'h000;
    localparam logic [PAGE_BITS-1:0] OFF_SYS_MASK = 12'h004;
    localparam logic [PAGE_BITS-1:0] OFF_SYS_MSET = 12'h008;
    localparam logic [PAGE_BITS-1:0] OFF_SYS_MCLR = 12'h00C;
    localparam logic [PAGE_BITS-1:0] OFF_SYS_TGT  = 12'h010;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_CPU_PEND,
        RD_SYS_PEND,
        RD_SYS_MASK,
        RD_SYS_TGT
    } rd_src_e;

    // Fixed priority of each device source position
    function automatic logic [LVL_W-1:0] src_level(input int unsigned b);
        logic [LVL_W-1:0] l;
        case (b)
            0, 7:        l = 4'd2;
            1, 8:        l = 4'd3;
            2, 9:        l = 4'd5;
            3, 10:       l = 4'd7;
            4, 11:       l = 4'd9;
            5, 12:       l = 4'd11;
            6, 13:       l = 4'd13;
            14, 15:      l = 4'd12;
            16:          l = 4'd6;
            17:          l = 4'd13;
            18:          l = 4'd4;
            19:          l = 4'd10;
            20:          l = 4'd8;
            21:          l = 4'd9;
            22:          l = 4'd11;
            28, 29, 30:  l = 4'd15;
            default:     l = 4'd0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 15,
    parameter int CPU_W  = 2
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [NCPU-1:0]   cpu_set_we,
    output logic [NCPU-1:0]   cpu_clr_we,
    output logic              msk_set_we,
    output logic              msk_clr_we,
    output logic              tgt_we,
    output rd_src_e           rd_src,
    output logic [CPU_W-1:0]  rd_cpu
);

    localparam int PG_W = ADDR_W - PAGE_BITS;

    logic [PG_W-1:0]      page;
    logic [PAGE_BITS-1:0] off;

    assign page = addr[ADDR_W-1:PAGE_BITS];
    assign off  = addr[PAGE_BITS-1:0];

    always_comb begin
        cpu_set_we = '0;
        cpu_clr_we = '0;
        msk_set_we = 1'b0;
        msk_clr_we = 1'b0;
        tgt_we     = 1'b0;
        rd_src     = RD_NONE;
        rd_cpu     = '0;
        if (req) begin
            for (int c = 0; c < NCPU; c++) begin
                if (int'(page) == c) begin
                    if (we) begin
                        if (off == OFF_CPU_SET) cpu_set_we[c] = 1'b1;
                        if (off == OFF_CPU_CLR) cpu_clr_we[c] = 1'b1;
                    end else if (off == OFF_CPU_PEND) begin
                        rd_src = RD_CPU_PEND;
                        rd_cpu = CPU_W'(c);
                    end
                end
            end
            if (int'(page) == NCPU) begin
                if (we) begin
                    msk_set_we = (off == OFF_SYS_MSET);
                    msk_clr_we = (off == OFF_SYS_MCLR);
                    tgt_we     = (off == OFF_SYS_TGT);
                end else begin
                    case (off)
                        OFF_SYS_PEND: rd_src = RD_SYS_PEND;
                        OFF_SYS_MASK: rd_src = RD_SYS_MASK;
                        OFF_SYS_TGT:  rd_src = RD_SYS_TGT;
                        default:      rd_src = RD_NONE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/irqc_soft_bank.sv
module irqc_soft_bank
    import irqc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCPU-1:0]                   set_we,
    input  logic [NCPU-1:0]                   clr_we,
    input  logic [SOFT_N-1:0]                 bits,
    output logic [NCPU-1:0][SOFT_N-1:0]       pend,
    output logic [NCPU-1:0][LVL_W-1:0]        level
);

    typedef struct packed {
        logic [NCPU-1:0][SOFT_N-1:0] flags;
    } soft_state_t;

    soft_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCPU; c++) begin
            if (set_we[c]) st_d.flags[c] = st_q.flags[c] | bits;
            if (clr_we[c]) st_d.flags[c] = st_q.flags[c] & ~bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.flags;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_comb begin
            level[c] = '0;
            for (int i = 0; i < SOFT_N; i++) begin
                if (st_q.flags[c][i]) level[c] = LVL_W'(i + 1);
            end
        end

        assert_soft_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_we[c] |=> ((pend[c] & $past(bits)) == $past(bits)));

        assert_soft_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            clr_we[c] |=> ((pend[c] & $past(bits)) == '0));

        assert_soft_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_we[c] && !clr_we[c]) |=> $stable(pend[c]));
    end

endmodule

// File: rtl/irqc_sys_ctrl.sv
module irqc_sys_ctrl
    import irqc_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] dev_req,
    input  logic [WORD_W-1:0] wdata,
    input  logic              msk_set_we,
    input  logic              msk_clr_we,
    input  logic              tgt_we,
    output logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] pend,
    output logic [CPU_W-1:0]  target,
    output logic [LVL_W-1:0]  sys_level
);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] pend;
        logic [CPU_W-1:0]  tgt;
    } sys_state_t;

    sys_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = dev_req & SRC_VALID;
        if (msk_set_we) st_d.mask = st_q.mask | wdata;
        if (msk_clr_we) st_d.mask = st_q.mask & ~wdata;
        if (tgt_we)     st_d.tgt  = wdata[CPU_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.pend <= '0;
            st_q.tgt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask   = st_q.mask;
    assign pend   = st_q.pend;
    assign target = st_q.tgt;

    always_comb begin
        sys_level = '0;
        if (!st_q.mask[MASK_ALL_BIT]) begin
            for (int b = 0; b < WORD_W; b++) begin
                if (st_q.pend[b] && !st_q.mask[b] && (src_level(b) > sys_level))
                    sys_level = src_level(b);
            end
        end
    end

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msk_set_we |=> ((mask & $past(wdata)) == $past(wdata)));

    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msk_clr_we |=> ((mask & $past(wdata)) == '0));

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!msk_set_we && !msk_clr_we) |=> $stable(mask));

    assert_mask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask[MASK_ALL_BIT] |-> (sys_level == '0));

    assert_tgt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_we |=> $stable(target));

endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCPU-1:0][LVL_W-1:0]  soft_level,
    input  logic [LVL_W-1:0]            sys_level,
    input  logic [CPU_W-1:0]            target,
    output logic [NCPU-1:0][LVL_W-1:0]  level
);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_comb begin
            level[c] = soft_level[c];
            if ((int'(target) == c) && (sys_level > soft_level[c]))
                level[c] = sys_level;
        end

        assert_level_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (level[c] >= soft_level[c]));

        assert_untargeted_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(target) != c) |-> (level[c] == soft_level[c]));
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irqc_pkg::*;
#(
    parameter  int NCPU   = 4,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int ADDR_W = $clog2((NCPU + 1) << PAGE_BITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    input  logic [WORD_W-1:0]       dev_req,
    output logic [NCPU*LVL_W-1:0]   cpu_level
);

    logic [NCPU-1:0]              cpu_set_we, cpu_clr_we;
    logic                         msk_set_we, msk_clr_we, tgt_we;
    rd_src_e                      rd_src;
    logic [CPU_W-1:0]             rd_cpu;
    logic [NCPU-1:0][SOFT_N-1:0]  soft_pend;
    logic [NCPU-1:0][LVL_W-1:0]   soft_level;
    logic [NCPU-1:0][LVL_W-1:0]   level;
    logic [WORD_W-1:0]            sys_mask, sys_pend;
    logic [CPU_W-1:0]             sys_tgt;
    logic [LVL_W-1:0]             sys_level;

    irqc_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_decode (
        .req        (bus_req),
        .we         (bus_we),
        .addr       (bus_addr),
        .cpu_set_we (cpu_set_we),
        .cpu_clr_we (cpu_clr_we),
        .msk_set_we (msk_set_we),
        .msk_clr_we (msk_clr_we),
        .tgt_we     (tgt_we),
        .rd_src     (rd_src),
        .rd_cpu     (rd_cpu)
    );

    irqc_soft_bank #(.NCPU(NCPU)) u_soft (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (cpu_set_we),
        .clr_we (cpu_clr_we),
        .bits   (bus_wdata[WORD_W-1:SOFT_LSB]),
        .pend   (soft_pend),
        .level  (soft_level)
    );

    irqc_sys_ctrl #(.NCPU(NCPU), .CPU_W(CPU_W)) u_sys (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req    (dev_req),
        .wdata      (bus_wdata),
        .msk_set_we (msk_set_we),
        .msk_clr_we (msk_clr_we),
        .tgt_we     (tgt_we),
        .mask       (sys_mask),
        .pend       (sys_pend),
        .target     (sys_tgt),
        .sys_level  (sys_level)
    );

    irqc_route #(.NCPU(NCPU), .CPU_W(CPU_W)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_level (soft_level),
        .sys_level  (sys_level),
        .target     (sys_tgt),
        .level      (level)
    );

    assign cpu_level = level;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d.rdata = '0;
        case (rd_src)
            RD_CPU_PEND: rd_d.rdata = {soft_pend[rd_cpu], {SOFT_LSB{1'b0}}};
            RD_SYS_PEND: rd_d.rdata = sys_pend;
            RD_SYS_MASK: rd_d.rdata = sys_mask;
            RD_SYS_TGT:  rd_d.rdata = {{(WORD_W-CPU_W){1'b0}}, sys_tgt};
            default:     rd_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (rd_src == RD_NONE)) |=> (bus_rdata == '0));

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> (bus_rdata == '0));

endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;

    localparam int NCPU   = 4;
    localparam int ADDR_W = $clog2((NCPU + 1) << 12);
    localparam int SYSB   = NCPU * 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       dev_req = '0;
    logic [NCPU*4-1:0] cpu_level;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    irq_route_ctrl #(.NCPU(NCPU)) u_irq_route_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dev_req   (dev_req),
        .cpu_level (cpu_level)
    );

    // Priority table written from the requirement (R7)
    function automatic int prio_of(input int b);
        if (b <= 13) return ((b % 7) == 0) ? 2 : 2 * (b % 7) + 1;
        if (b == 14 || b == 15) return 12;
        if (b == 16) return 6;
        if (b == 17) return 13;
        if (b == 18) return 4;
        if (b == 19) return 10;
        if (b == 20) return 8;
        if (b == 21) return 9;
        if (b == 22) return 11;
        if (b >= 28 && b <= 30) return 15;
        return 0;
    endfunction

    // Behavioural reference model
    logic [31:0] m_soft [NCPU];
    logic [31:0] m_mask, m_pend, m_rd;
    int          m_tgt;

    always @(posedge clk) begin
        int page, off;
        if (!rst_n) begin
            for (int c = 0; c < NCPU; c++) m_soft[c] = 0;
            m_mask = 32'hFFFF_FFFF;
            m_pend = 0;
            m_rd   = 0;
            m_tgt  = 0;
        end else begin
            page = int'(bus_addr) / 4096;
            off  = int'(bus_addr) % 4096;
            m_rd = 0;
            if (bus_req && !bus_we) begin
                if (page < NCPU && off == 0) m_rd = m_soft[page];
                if (page == NCPU && off == 0) m_rd = m_pend;
                if (page == NCPU && off == 4) m_rd = m_mask;
                if (page == NCPU && off == 16) m_rd = 32'(m_tgt);
            end
            for (int b = 0; b < 32; b++) m_pend[b] = dev_req[b] && (prio_of(b) != 0);
            if (bus_req && bus_we) begin
                if (page < NCPU && off == 8) m_soft[page] = m_soft[page] | (bus_wdata & 32'hFFFE_0000);
                if (page < NCPU && off == 4) m_soft[page] = m_soft[page] & ~bus_wdata;
                if (page == NCPU && off == 8) m_mask = m_mask | bus_wdata;
                if (page == NCPU && off == 12) m_mask = m_mask & ~bus_wdata;
                if (page == NCPU && off == 16) m_tgt = int'(bus_wdata) % NCPU;
            end
        end
    end

    function automatic int ref_level(input int c);
        int best = 0;
        for (int n = 1; n <= 15; n++) if (m_soft[c][16+n]) best = n;
        if (c == m_tgt && !m_mask[31])
            for (int b = 0; b < 32; b++)
                if (m_pend[b] && !m_mask[b] && prio_of(b) > best) best = prio_of(b);
        return best;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model comparison on every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCPU; c++)
                check("R9 model level", 32'(cpu_level[c*4 +: 4]), 32'(ref_level(c)));
            check("R11 model rdata", bus_rdata, m_rd);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_req = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic lvl(input int c, input int exp, input string tag);
        @(negedge clk);
        check(tag, 32'(cpu_level[c*4 +: 4]), 32'(exp));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < NCPU; c++) lvl(c, 0, "R1 level");
        rd(SYSB + 4,  32'hFFFF_FFFF, "R1 mask");
        rd(SYSB + 16, 32'h0, "R1 target");
        rd(0,         32'h0, "R1 soft pending");

        // R2 set port, low bits ignored
        wr(4096 + 8, 32'h0020_FFFF);
        rd(4096, 32'h0020_0000, "R2 set");
        lvl(1, 5, "R2 level");
        lvl(0, 0, "R2 other cpu");
        wr(4096 + 8, 32'h0200_0000);
        lvl(1, 9, "R9 soft max");

        // R3 clear port
        wr(4096 + 4, 32'h0);
        rd(4096, 32'h0220_0000, "R3 zero write");
        wr(4096 + 4, 32'h0200_0000);
        rd(4096, 32'h0020_0000, "R3 clear");
        lvl(1, 5, "R3 level");

        // R5 pending view regardless of mask
        @(negedge clk) dev_req = 32'h0204_0000;
        rd(SYSB, 32'h0004_0000, "R5 pending");
        lvl(0, 0, "R4 masked");

        // R4 / R6 mask ports and mask-all
        wr(SYSB + 12, 32'h7FFF_FFFF);
        rd(SYSB + 4, 32'h8000_0000, "R4 mask clear");
        lvl(0, 0, "R6 mask all");
        wr(SYSB + 12, 32'h8000_0000);
        lvl(0, 4, "R7 scsi");

        // R11 timing of a request change
        @(negedge clk) dev_req = 32'h020C_0000;
        #1 check("R11 before edge", 32'(cpu_level[3:0]), 32'd4);
        @(negedge clk) check("R11 after edge", 32'(cpu_level[3:0]), 32'd10);

        // R8 target steering
        wr(SYSB + 16, 32'h1);
        rd(SYSB + 16, 32'h1, "R8 target read");
        lvl(0, 0, "R8 old target");
        lvl(1, 10, "R8 new target");
        wr(SYSB + 8, 32'h0008_0000);
        rd(SYSB + 4, 32'h0008_0000, "R4 mask set");
        lvl(1, 5, "R9 soft over scsi");
        wr(SYSB + 8, 32'h8000_0000);
        lvl(1, 5, "R6 soft unaffected");
        wr(SYSB + 12, 32'h8008_0000);
        lvl(1, 10, "R4 reenable");

        // R10 write-only, unmapped, read-only
        rd(4, 32'h0, "R10 cpu clr read");
        rd(8, 32'h0, "R10 cpu set read");
        rd(SYSB + 8,  32'h0, "R10 mset read");
        rd(SYSB + 12, 32'h0, "R10 mclr read");
        wr(SYSB + 32, 32'hFFFF_FFFF);
        rd(SYSB + 32, 32'h0, "R10 unmapped");
        wr(SYSB, 32'hFFFF_FFFF);
        wr(SYSB + 4096 + 8, 32'hFFFF_FFFF);
        rd(SYSB + 4, 32'h0, "R10 mask untouched");
        wr(2 * 4096, 32'hFFFF_FFFF);
        rd(2 * 4096, 32'h0, "R10 pending untouched");

        // R9 highest of several soft levels
        wr(2 * 4096 + 8, 32'h8008_0000);
        lvl(2, 15, "R9 soft 15");
        wr(2 * 4096 + 4, 32'hFFFF_FFFF);
        lvl(2, 0, "R9 none");

        // R7 full table on cpu0
        wr(SYSB + 16, 32'h0);
        wr(4096 + 4, 32'hFFFF_FFFF);
        for (int b = 0; b < 32; b++) begin
            @(negedge clk) dev_req = 32'h1 << b;
            lvl(0, prio_of(b), "R7 table");
            check("R8 idle cpu", 32'(cpu_level[7:4]), 32'd0);
        end

        // R4 masking the top group
        @(negedge clk) dev_req = 32'h707F_FFFF;
        lvl(0, 15, "R7 all on");
        wr(SYSB + 8, 32'h7000_0000);
        lvl(0, 13, "R4 errors masked");
        wr(SYSB + 16, 32'h3);
        lvl(3, 13, "R8 cpu3");
        lvl(0, 0, "R8 cpu0 released");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule